// File: doc/BRIEF.md
# Carry-Skip Adder with Inverting Skip Chain and Stage Incrementers

A purely combinational binary adder. It adds two operands and a single carry-in bit and returns a sum of the same width plus a carry-out. The operand bits are cut into equal, consecutive stages. The carry-in of a stage never enters that stage's full adders. Each stage first sums its own operand slice with a ripple chain whose carry-in is tied to zero. A half-adder incrementer then adds the carry that arrives from the stage below.

The carry that travels from stage to stage passes through one compound gate per stage. Even-indexed stages use an AND-OR-Invert function and odd-indexed stages use an OR-AND-Invert function. Each gate inverts, so the chain wire between two stages is true on even boundaries and complemented on odd ones. The next gate is chosen to accept that polarity. The external carry-out is always delivered in true polarity, whatever the stage count. The stage width is a parameter. The default is 16 bits in four stages of four bits.

Top module: `csk_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin` for every input combination.
- R2: `cout` equals bit WIDTH of `a + b + cin`, i.e. it is 1 exactly when the unsigned total exceeds 2^WIDTH - 1.
- R3: When every bit of a stage has `a[i] XOR b[i] = 1`, the carry leaving that stage equals the carry entering it. With `b = ~a` over the whole word, `cout == cin` and `sum` is all ones for `cin = 0` and all zeros for `cin = 1`.
- R4: The inter-stage carry chain alternates polarity. The wire after stage k (k counted from 0 at the least significant stage) holds the complement of the arithmetic carry into bit (k+1)*STAGE_W when k is even, and the true carry when k is odd.
- R5: `cout` is in true polarity for both an even and an odd number of stages. This is checked with the default four-stage build and a 12-bit three-stage build.
- R6: All-zero operands with `cin = 0` give `sum = 0` and `cout = 0`. All-ones operands with `cin = 1` give `sum` all ones and `cout = 1`.
- R7: A carry generated inside a stage reaches every higher stage. This holds whether those stages skip, generate, or kill the carry, including a carry generated in the lowest stage that must cross all higher stages through their skip paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | first operand |
| b | input | WIDTH | second operand |
| cin | input | 1 | carry into the least significant bit |
| sum | output | WIDTH | low WIDTH bits of the total |
| cout | output | 1 | carry out of the most significant bit, true polarity |

## Verification
Two functions of the same stage can be active for one input vector: the skip path that forwards the incoming carry, and the incrementer that absorbs the same carry into an all-ones intermediate sum. The bench provokes this overlap with propagate-everywhere operands (`b = ~a`, swept over every 12-bit value) and with stage masks that force chosen stages into all-propagate while the lower stages generate a carry. Each result is judged against the arithmetic total computed in the bench. The checker also compares every chain wire, after polarity correction, with the carry recomputed from the partial operand sums.

// File: rtl/csk_pkg.sv
package csk_pkg;

  typedef enum logic {
    GATE_AOI = 1'b0,
    GATE_OAI = 1'b1
  } skip_gate_e;

  // gate kind placed on stage idx: even stages invert-from-true, odd stages invert-from-complement
  function automatic skip_gate_e gate_for_stage(input int idx);
    return (idx % 2 == 0) ? GATE_AOI : GATE_OAI;
  endfunction

  // chain wire j (input of stage j) is complemented when j is odd
  function automatic bit chain_is_inverted(input int j);
    return (j % 2) == 1;
  endfunction

endpackage

// File: rtl/csk_rca.sv
module csk_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         gen,
  output logic         prop_all
);

  logic [W:0]   rc;
  logic [W-1:0] pbit;

  assign rc[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign pbit[i]  = a[i] ^ b[i];
    assign s[i]     = pbit[i] ^ rc[i];
    assign rc[i+1]  = (a[i] & b[i]) | (pbit[i] & rc[i]);
  end

  assign gen      = rc[W];
  assign prop_all = &pbit;

endmodule

// File: rtl/csk_incr.sv
module csk_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic         ci,
  output logic [W-1:0] y
);

  logic [W:0] hc;

  assign hc[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign y[i]    = x[i] ^ hc[i];
    assign hc[i+1] = x[i] & hc[i];
  end

endmodule

// File: rtl/csk_skip.sv
module csk_skip
  import csk_pkg::*;
#(
  parameter skip_gate_e KIND = GATE_AOI
) (
  input  logic gen,
  input  logic prop,
  input  logic c_raw,
  output logic c_out_raw
);

  if (KIND == GATE_AOI) begin : g_aoi
    // true-polarity inputs, complemented output
    assign c_out_raw = ~(gen | (prop & c_raw));
  end else begin : g_oai
    // complemented inputs, true-polarity output
    logic gen_n;
    logic prop_n;
    assign gen_n     = ~gen;
    assign prop_n    = ~prop;
    assign c_out_raw = ~(gen_n & (prop_n | c_raw));
  end

endmodule

// File: rtl/csk_stage.sv
module csk_stage
  import csk_pkg::*;
#(
  parameter int W   = 4,
  parameter int IDX = 0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in_raw,
  output logic [W-1:0] s,
  output logic         c_out_raw
);

  localparam skip_gate_e KIND   = gate_for_stage(IDX);
  localparam bit         IN_INV = chain_is_inverted(IDX);

  logic [W-1:0] mid;
  logic         gen;
  logic         prop_all;
  logic         c_true;

  csk_rca #(.W(W)) u_rca (
    .a        (a),
    .b        (b),
    .s        (mid),
    .gen      (gen),
    .prop_all (prop_all)
  );

  csk_skip #(.KIND(KIND)) u_skip (
    .gen       (gen),
    .prop      (prop_all),
    .c_raw     (c_in_raw),
    .c_out_raw (c_out_raw)
  );

  if (IN_INV) begin : g_restore
    assign c_true = ~c_in_raw;
  end else begin : g_pass
    assign c_true = c_in_raw;
  end

  csk_incr #(.W(W)) u_incr (
    .x  (mid),
    .ci (c_true),
    .y  (s)
  );

endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int STAGE_W = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int  NSTG    = WIDTH / STAGE_W;
  localparam bit  OUT_INV = chain_is_inverted(NSTG);

  if (NSTG * STAGE_W != WIDTH) begin : g_bad_cfg
    initial $error("csk_adder: WIDTH must be a multiple of STAGE_W");
  end

  logic [NSTG:0] chain;

  assign chain[0] = cin;

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    csk_stage #(.W(STAGE_W), .IDX(k)) u_stage (
      .a         (a[k*STAGE_W +: STAGE_W]),
      .b         (b[k*STAGE_W +: STAGE_W]),
      .c_in_raw  (chain[k]),
      .s         (sum[k*STAGE_W +: STAGE_W]),
      .c_out_raw (chain[k+1])
    );
  end

  if (OUT_INV) begin : g_out_fix
    assign cout = ~chain[NSTG];
  end else begin : g_out_pass
    assign cout = chain[NSTG];
  end

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int WIDTH   = 16,
  parameter int STAGE_W = 4,
  parameter int NSTG    = WIDTH / STAGE_W
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NSTG:0]    chain
);

  always_comb begin
    logic [WIDTH:0] total;
    total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assert_sum_R1: assert (sum == total[WIDTH-1:0])
      else $error("sum mismatch");
    assert_carry_out_R2: assert (cout == total[WIDTH])
      else $error("cout mismatch");
    for (int k = 0; k < NSTG; k++) begin
      logic [WIDTH:0] msk;
      logic [WIDTH:0] part;
      logic           c_true_out;
      logic           c_true_in;
      msk  = ~({(WIDTH+1){1'b1}} << ((k+1)*STAGE_W));
      part = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{WIDTH{1'b0}}, cin};
      c_true_out = part[(k+1)*STAGE_W];
      // R4: even-index stage outputs complemented carry, odd-index true
      assert_chain_polarity_R4: assert (chain[k+1] == (((k % 2) == 0) ? ~c_true_out : c_true_out))
        else $error("chain polarity wrong after stage %0d", k);
      c_true_in  = ((k % 2) == 1) ? ~chain[k] : chain[k];
      c_true_out = ((k % 2) == 0) ? ~chain[k+1] : chain[k+1];
      assert_skip_pass_R3: assert (!(&(a[k*STAGE_W +: STAGE_W] ^ b[k*STAGE_W +: STAGE_W]))
                                   || (c_true_out == c_true_in))
        else $error("skip stage %0d altered carry", k);
    end
    assert_cout_true_R5: assert (cout == ((NSTG % 2 == 1) ? ~chain[NSTG] : chain[NSTG]))
      else $error("cout polarity wrong");
  end

endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .STAGE_W(STAGE_W)) u_chk (
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .chain (chain)
);

// File: tb/sim_csk_adder.sv
module sim_csk_adder;

  logic        clk;
  logic        rst_n;
  logic [15:0] a;
  logic [15:0] b;
  logic        cin;
  logic [15:0] sum0;
  logic        cout0;
  logic [11:0] sum1;
  logic        cout1;

  int vecs  = 0;
  int fails = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  csk_adder #(.WIDTH(16), .STAGE_W(4)) u0 (
    .a (a), .b (b), .cin (cin), .sum (sum0), .cout (cout0)
  );

  // three stages: odd count, last chain wire is complemented
  csk_adder #(.WIDTH(12), .STAGE_W(4)) u1 (
    .a (a[11:0]), .b (b[11:0]), .cin (cin), .sum (sum1), .cout (cout1)
  );

  task automatic apply(input logic [15:0] av, input logic [15:0] bv,
                       input logic ci, input string req);
    logic [16:0] e16;
    logic [12:0] e12;
    @(negedge clk);
    a   = av;
    b   = bv;
    cin = ci;
    #1;
    e16 = {1'b0, av} + {1'b0, bv} + {16'd0, ci};
    e12 = {1'b0, av[11:0]} + {1'b0, bv[11:0]} + {12'd0, ci};
    vecs++;
    if ({cout0, sum0} !== e16) begin
      fails++;
      $display("FAIL %s 16b a=%h b=%h cin=%b got=%h exp=%h", req, av, bv, ci,
               {cout0, sum0}, e16);
    end else if ({cout1, sum1} !== e12) begin
      fails++;
      $display("FAIL %s 12b a=%h b=%h cin=%b got=%h exp=%h", req, av[11:0],
               bv[11:0], ci, {cout1, sum1}, e12);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle inputs, R6 zero case
    apply(16'h0000, 16'h0000, 1'b0, "R6");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R2");
    // R3: whole word propagates, both carry values
    apply(16'h5A3C, ~16'h5A3C, 1'b0, "R3");
    apply(16'h5A3C, ~16'h5A3C, 1'b1, "R3");
    apply(16'h0000, 16'hFFFF, 1'b1, "R3");
    // R7: carry born in lowest stage crosses three skipping stages
    apply(16'h0008, 16'hFFF8, 1'b0, "R7");
    apply(16'h000F, 16'hFFF1, 1'b0, "R7");
    // R4 / R5: stage masks force chosen stages to all-propagate
    for (int m = 0; m < 16; m++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int r = 0; r < 150; r++) begin
          logic [15:0] av;
          logic [15:0] bv;
          av = 16'($urandom);
          bv = 16'($urandom);
          for (int s = 0; s < 4; s++) begin
            if (m[s]) bv[s*4 +: 4] = ~av[s*4 +: 4];
          end
          apply(av, bv, ci[0], "R4");
        end
      end
    end
    // R3 / R5: every 12-bit value against its complement and itself
    for (int v = 0; v < 4096; v++) begin
      logic [15:0] av;
      av = {4'($urandom), 12'(v)};
      apply(av, ~av, 1'(v >> 3), "R3");
      apply(av, av, 1'(v), "R5");
    end
    // R1 / R2: random operands
    for (int r = 0; r < 40000; r++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule